// File: doc/BRIEF.md
# Ternary AND-Inverter Graph Evaluator

This block runs one round of three-valued simulation (logic 0, logic 1 and unknown X) over an AND-inverter netlist. The netlist is a list of records in a record memory outside the block. Each record holds three fields: a target node index and two fanin literals. A literal carries a node index in its upper bits and an invert flag in bit 0. The type of a record is not given by an opcode. It is read from which fanin fields are zero: an input record loads the next primary value, a gate record evaluates a two-input AND, and an output record stores a result.

Input values come from a packed input memory and results go to a packed output memory. Both are outside the block and use the same 2-bit-per-entry packing. Node values live in a packed store inside the block. The block handles one record per clock cycle.

A round is launched with a one-cycle `start` pulse. Software must hold the configuration pins stable while `busy` is high. The round ends with a one-cycle `done` pulse, and `err` reports whether the number of input and output records met the configured counts. All three memory ports read combinationally in the same cycle as the address. The output write is taken at the clock edge.

Top module: `tern_aig_eval`

## Requirements
- R1: After reset, `busy`, `done` and `err` are all 0 and `out_we` is 0.
- R2: A `start` pulse seen while idle makes `busy` high at the next edge, and the first record fetched is address 2. Records 0 and 1 are reserved and never evaluated.
- R3: A record whose first fanin field (bits [13:7]) is zero is an input record. It copies input entry k into the node slot named by its target field (bits [6:0]), where k counts the input records already seen in this round.
- R4: A gate record has both fanin fields nonzero (second fanin at bits [20:14]). It writes X if either fanin value is X. Otherwise it writes 0 if either fanin, after inversion, is 0. Otherwise it writes 1.
- R5: Bit 0 of a literal inverts the fanin: 0 becomes 1 and 1 becomes 0, while X stays X. The node index is in literal bits [6:1].
- R6: A record with a nonzero first fanin field and a zero second fanin field is an output record. It writes the possibly inverted fanin value into output entry m, where m counts the output records already seen. The write is read-modify-write: only that entry's 2-bit field in the word changes.
- R7: When `cfg_const_used` is 1, input entry 1 is taken as logic 1 whatever the input memory holds. When it is 0, input entry 1 is read normally.
- R8: With N = `cfg_num_recs` and N >= 3, `done` pulses for exactly one cycle at the N-2th edge after the start edge, and `busy` falls on that edge. With N <= 2, no record is evaluated and `done` pulses at the first edge after the start edge.
- R9: At `done`, `err` is 1 exactly when the number of input records differs from `cfg_num_ci` or the number of output records differs from `cfg_num_co`. `err` holds until the next accepted start.
- R10: A `start` pulse while `busy` is high is ignored. The walk, its timing and its results are unchanged.
- R11: Values use the code 01 for logic 0, 10 for logic 1 and 11 for X. Entry i sits in word i>>4 at bits [2*(i&15)+1 : 2*(i&15)].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a round when idle |
| cfg_num_recs | input | 7 | Number of records, reserved ones included |
| cfg_num_ci | input | 7 | Expected count of input records |
| cfg_num_co | input | 7 | Expected count of output records |
| cfg_const_used | input | 1 | Forces input entry 1 to logic 1 |
| rec_addr | output | 6 | Record memory address |
| rec_data | input | 21 | Record read at `rec_addr`: {fanin2, fanin1, target} |
| in_addr | output | 1 | Input-value memory word address |
| in_rdata | input | 32 | Input-value word at `in_addr` |
| out_addr | output | 1 | Output-value memory word address |
| out_rdata | input | 32 | Output-value word at `out_addr` |
| out_we | output | 1 | Output word write enable |
| out_wdata | output | 32 | Merged output word to write |
| busy | output | 1 | Round in progress |
| done | output | 1 | One-cycle end-of-round pulse |
| err | output | 1 | Input or output count mismatch |

## Verification
The bench builds the block with its default parameters: 64 node slots, 64 records, and 32 input and 32 output entries. With these values each value memory spans two packed words. Random netlists with up to twenty-four outputs therefore cross the word boundary and test that neighbouring fields survive each merge. The full record depth is also in reach, so long walks with interleaved gate and output records are exercised, along with minimal rounds of two and three records.

// File: rtl/tav_pkg.sv
package tav_pkg;
  typedef logic [1:0] tv_t;

  localparam tv_t TV_ZERO = 2'b01;
  localparam tv_t TV_ONE  = 2'b10;
  localparam tv_t TV_X    = 2'b11;

  typedef enum logic [1:0] {
    RK_INPUT  = 2'd0,
    RK_OUTPUT = 2'd1,
    RK_GATE   = 2'd2
  } rec_kind_t;

  // true when the fanin, after its invert flag, is a known zero
  function automatic logic lit_is_zero(tv_t v, logic inv);
    return inv ? (v == TV_ONE) : (v == TV_ZERO);
  endfunction

  function automatic tv_t tv_apply(tv_t v, logic inv);
    if (v == TV_X) return TV_X;
    return lit_is_zero(v, inv) ? TV_ZERO : TV_ONE;
  endfunction

  function automatic tv_t tv_and2(tv_t a, logic ia, tv_t b, logic ib);
    if (a == TV_X || b == TV_X) return TV_X;
    if (lit_is_zero(a, ia) || lit_is_zero(b, ib)) return TV_ZERO;
    return TV_ONE;
  endfunction

  function automatic tv_t slot_get(logic [31:0] w, logic [3:0] s);
    return w[{s, 1'b0} +: 2];
  endfunction

  function automatic logic [31:0] slot_put(logic [31:0] w, logic [3:0] s, tv_t v);
    logic [31:0] r;
    r = w;
    r[{s, 1'b0} +: 2] = v;
    return r;
  endfunction
endpackage

// File: rtl/tav_value_store.sv
module tav_value_store
  import tav_pkg::*;
#(
  parameter int NODES  = 64,
  parameter int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODE_W-1:0] rd_a_idx,
  output tv_t               rd_a_val,
  input  logic [NODE_W-1:0] rd_b_idx,
  output tv_t               rd_b_val,
  input  logic              wr_en,
  input  logic [NODE_W-1:0] wr_idx,
  input  tv_t               wr_val
);
  localparam int WORDS = (NODES + 15) / 16;
  localparam int WA_W  = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [31:0]     words [WORDS];
  logic [WA_W-1:0] wr_word, rd_a_word, rd_b_word;

  assign wr_word   = WA_W'(wr_idx >> 4);
  assign rd_a_word = WA_W'(rd_a_idx >> 4);
  assign rd_b_word = WA_W'(rd_b_idx >> 4);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        words[w] <= '1;
      else if (wr_en && wr_word == WA_W'(w))
        words[w] <= slot_put(words[w], wr_idx[3:0], wr_val);
    end
  end

  assign rd_a_val = slot_get(words[rd_a_word], rd_a_idx[3:0]);
  assign rd_b_val = slot_get(words[rd_b_word], rd_b_idx[3:0]);
endmodule

// File: rtl/tav_record_eval.sv
module tav_record_eval
  import tav_pkg::*;
#(
  parameter int LIT_W  = 7,
  parameter int NODE_W = 6,
  parameter int CNT_W  = 7,
  parameter int IA_W   = 1,
  parameter int OA_W   = 1
) (
  input  logic               active,
  input  logic [3*LIT_W-1:0] rec_data,
  input  logic               const_used,
  input  logic [CNT_W-1:0]   ci_cnt,
  input  logic [CNT_W-1:0]   co_cnt,
  input  logic [31:0]        in_rdata,
  input  logic [31:0]        out_rdata,
  input  tv_t                val_a,
  input  tv_t                val_b,
  output rec_kind_t          kind,
  output logic [NODE_W-1:0]  rd_a_idx,
  output logic [NODE_W-1:0]  rd_b_idx,
  output logic               node_we,
  output logic [NODE_W-1:0]  node_idx,
  output tv_t                node_val,
  output logic [IA_W-1:0]    in_addr,
  output logic [OA_W-1:0]    out_addr,
  output logic               out_we,
  output logic [31:0]        out_wdata
);
  logic [LIT_W-1:0] tgt, lit_a, lit_b;
  tv_t              ci_val;

  assign tgt   = rec_data[LIT_W-1:0];
  assign lit_a = rec_data[2*LIT_W-1:LIT_W];
  assign lit_b = rec_data[3*LIT_W-1:2*LIT_W];

  always_comb begin
    if (lit_a == '0)      kind = RK_INPUT;
    else if (lit_b == '0) kind = RK_OUTPUT;
    else                  kind = RK_GATE;
  end

  assign rd_a_idx = lit_a[LIT_W-1:1];
  assign rd_b_idx = lit_b[LIT_W-1:1];
  assign in_addr  = IA_W'(ci_cnt >> 4);
  assign out_addr = OA_W'(co_cnt >> 4);

  always_comb begin
    ci_val = slot_get(in_rdata, ci_cnt[3:0]);
    if (const_used && ci_cnt == CNT_W'(1)) ci_val = TV_ONE;
  end

  assign node_we   = active && (kind != RK_OUTPUT);
  assign node_idx  = tgt[NODE_W-1:0];
  assign node_val  = (kind == RK_INPUT) ? ci_val
                                        : tv_and2(val_a, lit_a[0], val_b, lit_b[0]);
  assign out_we    = active && (kind == RK_OUTPUT);
  assign out_wdata = slot_put(out_rdata, co_cnt[3:0], tv_apply(val_a, lit_a[0]));
endmodule

// File: rtl/tav_sequencer.sv
module tav_sequencer
  import tav_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cfg_num_recs,
  input  logic [CNT_W-1:0] cfg_num_ci,
  input  logic [CNT_W-1:0] cfg_num_co,
  input  rec_kind_t        kind,
  output logic             busy,
  output logic             active,
  output logic [CNT_W-1:0] rec_idx,
  output logic [CNT_W-1:0] ci_cnt,
  output logic [CNT_W-1:0] co_cnt,
  output logic             done,
  output logic             err
);
  typedef enum logic {S_IDLE, S_WALK} st_t;

  st_t              st;
  logic [CNT_W-1:0] ci_nx, co_nx;
  logic [CNT_W:0]   idx_p1;
  logic             last;

  assign busy   = (st == S_WALK);
  assign active = busy && (rec_idx < cfg_num_recs);

  always_comb begin
    ci_nx  = ci_cnt + CNT_W'(active && kind == RK_INPUT);
    co_nx  = co_cnt + CNT_W'(active && kind == RK_OUTPUT);
    idx_p1 = {1'b0, rec_idx} + {{CNT_W{1'b0}}, 1'b1};
    last   = idx_p1 >= {1'b0, cfg_num_recs};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      rec_idx <= '0;
      ci_cnt  <= '0;
      co_cnt  <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st      <= S_WALK;
          rec_idx <= CNT_W'(2);
          ci_cnt  <= '0;
          co_cnt  <= '0;
          err     <= 1'b0;
        end
        default: begin
          ci_cnt  <= ci_nx;
          co_cnt  <= co_nx;
          rec_idx <= idx_p1[CNT_W-1:0];
          if (last) begin
            st   <= S_IDLE;
            done <= 1'b1;
            err  <= (ci_nx != cfg_num_ci) || (co_nx != cfg_num_co);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tern_aig_eval.sv
module tern_aig_eval
  import tav_pkg::*;
#(
  parameter int MAX_NODES = 64,
  parameter int MAX_RECS  = 64,
  parameter int MAX_CI    = 32,
  parameter int MAX_CO    = 32,
  localparam int NODE_W   = $clog2(MAX_NODES),
  localparam int LIT_W    = NODE_W + 1,
  localparam int REC_W    = 3 * LIT_W,
  localparam int RA_W     = $clog2(MAX_RECS),
  localparam int CNT_W    = $clog2(MAX_RECS + 1),
  localparam int CI_WORDS = (MAX_CI + 15) / 16,
  localparam int CO_WORDS = (MAX_CO + 15) / 16,
  localparam int IA_W     = (CI_WORDS > 1) ? $clog2(CI_WORDS) : 1,
  localparam int OA_W     = (CO_WORDS > 1) ? $clog2(CO_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cfg_num_recs,
  input  logic [CNT_W-1:0] cfg_num_ci,
  input  logic [CNT_W-1:0] cfg_num_co,
  input  logic             cfg_const_used,
  output logic [RA_W-1:0]  rec_addr,
  input  logic [REC_W-1:0] rec_data,
  output logic [IA_W-1:0]  in_addr,
  input  logic [31:0]      in_rdata,
  output logic [OA_W-1:0]  out_addr,
  input  logic [31:0]      out_rdata,
  output logic             out_we,
  output logic [31:0]      out_wdata,
  output logic             busy,
  output logic             done,
  output logic             err
);
  rec_kind_t         kind;
  logic              active, node_we;
  logic [CNT_W-1:0]  rec_idx, ci_cnt, co_cnt;
  logic [NODE_W-1:0] rd_a_idx, rd_b_idx, node_idx;
  tv_t               val_a, val_b, node_val;

  assign rec_addr = rec_idx[RA_W-1:0];

  tav_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_num_recs(cfg_num_recs), .cfg_num_ci(cfg_num_ci), .cfg_num_co(cfg_num_co),
    .kind(kind), .busy(busy), .active(active), .rec_idx(rec_idx),
    .ci_cnt(ci_cnt), .co_cnt(co_cnt), .done(done), .err(err)
  );

  tav_record_eval #(
    .LIT_W(LIT_W), .NODE_W(NODE_W), .CNT_W(CNT_W), .IA_W(IA_W), .OA_W(OA_W)
  ) u_eval (
    .active(active), .rec_data(rec_data), .const_used(cfg_const_used),
    .ci_cnt(ci_cnt), .co_cnt(co_cnt), .in_rdata(in_rdata), .out_rdata(out_rdata),
    .val_a(val_a), .val_b(val_b), .kind(kind),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .node_we(node_we), .node_idx(node_idx), .node_val(node_val),
    .in_addr(in_addr), .out_addr(out_addr), .out_we(out_we), .out_wdata(out_wdata)
  );

  tav_value_store #(.NODES(MAX_NODES), .NODE_W(NODE_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_val(val_a),
    .rd_b_idx(rd_b_idx), .rd_b_val(val_b),
    .wr_en(node_we), .wr_idx(node_idx), .wr_val(node_val)
  );
endmodule

// File: rtl/tav_checker.sv
module tav_checker #(
  parameter int RA_W  = 6,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [RA_W-1:0]  rec_addr,
  input logic [31:0]      out_rdata,
  input logic             out_we,
  input logic [31:0]      out_wdata,
  input logic             busy,
  input logic             done,
  input logic             err
);
  p_walk_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && rec_addr == RA_W'(2)));

  p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || rec_addr == $past(rec_addr) + RA_W'(1)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_one_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> ($countones(out_wdata ^ out_rdata) <= 2));

  p_write_in_walk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> busy);

  p_err_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
endmodule

bind tern_aig_eval tav_checker #(.RA_W(RA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rec_addr(rec_addr),
  .out_rdata(out_rdata), .out_we(out_we), .out_wdata(out_wdata),
  .busy(busy), .done(done), .err(err)
);

// File: tb/test_tern_aig_eval.sv
module test_tern_aig_eval;
  localparam int NODES = 64, RECS = 64, NCI = 32, NCO = 32;
  localparam int LW = 7, RW = 21, AW = 6, CW = 7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cu = 1'b0;
  logic [AW-1:0] rec_addr;
  logic [RW-1:0] rec_data;
  logic in_addr, out_addr, out_we, busy, done, err;
  logic [31:0] in_rdata, out_rdata, out_wdata;
  logic [RW-1:0] rec_mem [RECS];
  logic [31:0] in_mem [2];
  logic [31:0] out_mem [2];
  logic pre = 1'b0;
  logic [31:0] pre0 = '0, pre1 = '0;
  logic is_node [RECS];
  int nrec = 2, nci = 0, nco = 0;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  assign rec_data  = rec_mem[rec_addr];
  assign in_rdata  = in_mem[in_addr];
  assign out_rdata = out_mem[out_addr];

  always @(posedge clk) begin
    if (pre) begin
      out_mem[0] <= pre0;
      out_mem[1] <= pre1;
    end else if (out_we) out_mem[out_addr] <= out_wdata;
  end

  tern_aig_eval i_tern_aig_eval (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_num_recs(CW'(nrec)), .cfg_num_ci(CW'(nci)), .cfg_num_co(CW'(nco)),
    .cfg_const_used(cu), .rec_addr(rec_addr), .rec_data(rec_data),
    .in_addr(in_addr), .in_rdata(in_rdata), .out_addr(out_addr), .out_rdata(out_rdata),
    .out_we(out_we), .out_wdata(out_wdata), .busy(busy), .done(done), .err(err)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference ternary functions, written from the requirements
  function automatic logic [1:0] m_inv(logic [1:0] v, logic c);
    if (v == 2'b11) return 2'b11;
    if (c) return (v == 2'b10) ? 2'b01 : 2'b10;
    return (v == 2'b01) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [1:0] m_and(logic [1:0] a, logic ca, logic [1:0] b, logic cb);
    if (a == 2'b11 || b == 2'b11) return 2'b11;
    if (m_inv(a, ca) == 2'b01 || m_inv(b, cb) == 2'b01) return 2'b01;
    return 2'b10;
  endfunction

  function automatic logic [1:0] rcode();
    case ($urandom % 3)
      0: return 2'b01;
      1: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [RW-1:0] pack(int f0, int f1, int f2);
    return {LW'(f2), LW'(f1), LW'(f0)};
  endfunction

  task automatic ref_run(output logic [31:0] e0, output logic [31:0] e1, output logic ee);
    logic [1:0] nv [NODES];
    logic [31:0] eo [2];
    int ci = 0, co = 0;
    for (int i = 0; i < NODES; i++) nv[i] = 2'b11;
    eo[0] = out_mem[0];
    eo[1] = out_mem[1];
    for (int r = 2; r < nrec; r++) begin
      int f0 = int'(rec_mem[r][LW-1:0]);
      int f1 = int'(rec_mem[r][2*LW-1:LW]);
      int f2 = int'(rec_mem[r][3*LW-1:2*LW]);
      if (f1 == 0) begin
        logic [1:0] v = in_mem[ci/16][2*(ci%16) +: 2];
        if (cu && ci == 1) v = 2'b10;
        nv[f0] = v;
        ci++;
      end else if (f2 == 0) begin
        eo[co/16][2*(co%16) +: 2] = m_inv(nv[f1/2], f1[0]);
        co++;
      end else
        nv[f0] = m_and(nv[f1/2], f1[0], nv[f2/2], f2[0]);
    end
    e0 = eo[0];
    e1 = eo[1];
    ee = (ci != nci) || (co != nco);
  endtask

  task automatic preload(logic [31:0] w0, logic [31:0] w1);
    pre0 = w0; pre1 = w1; pre = 1'b1;
    @(negedge clk);
    pre = 1'b0;
  endtask

  task automatic clear_recs();
    for (int i = 0; i < RECS; i++) begin
      rec_mem[i] = '0;
      is_node[i] = 1'b0;
    end
  endtask

  function automatic int pick(int r);
    int c;
    do c = int'($urandom % r); while (!is_node[c]);
    return 2 * c + int'($urandom % 2);
  endfunction

  task automatic build(int n_in, int n_gate, int n_out);
    int r = 2, g = n_gate, o = n_out;
    clear_recs();
    for (int i = 0; i < n_in; i++) begin
      rec_mem[r] = pack(r, 0, 0); is_node[r] = 1'b1; r++;
    end
    while (g > 0 || o > 0) begin
      if (o > 0 && (g == 0 || $urandom % 3 == 0)) begin
        rec_mem[r] = pack(0, pick(r), 0); o--;
      end else begin
        rec_mem[r] = pack(r, pick(r), pick(r)); is_node[r] = 1'b1; g--;
      end
      r++;
    end
    nrec = r; nci = n_in; nco = n_out;
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 16; s++) in_mem[w][2*s +: 2] = rcode();
  endtask

  task automatic run_walk(int extra, output int cyc);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 1;
    chk("R2", {31'b0, busy}, 32'd1, "busy after start");
    if (nrec > 2) chk("R2", 32'(rec_addr), 32'd2, "first record address");
    while (!done && cyc < 2000) begin
      start = (cyc == extra);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
  endtask

  task automatic do_case(string tag, int extra);
    logic [31:0] e0, e1;
    logic ee;
    int cyc, expc;
    ref_run(e0, e1, ee);
    run_walk(extra, cyc);
    expc = (nrec < 3) ? 2 : nrec - 1;
    chk("R8", 32'(cyc), 32'(expc), {tag, " cycles to done"});
    chk("R9", {31'b0, err}, {31'b0, ee}, {tag, " count error flag"});
    chk(tag, out_mem[0], e0, "output word 0");
    chk(tag, out_mem[1], e1, "output word 1");
    @(negedge clk);
    chk("R8", {30'b0, done, busy}, 32'd0, {tag, " done single pulse"});
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] codes [3];
    codes[0] = 2'b01; codes[1] = 2'b10; codes[2] = 2'b11;
    void'($urandom(32'd2024));
    clear_recs();
    in_mem[0] = '0; in_mem[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk("R1", {28'b0, busy, done, err, out_we}, 32'd0, "reset state");

    // directed truth table over all code pairs: R3, R4, R5
    for (int ia = 0; ia < 3; ia++)
      for (int ib = 0; ib < 3; ib++) begin
        logic [1:0] a, b;
        a = codes[ia]; b = codes[ib];
        clear_recs();
        rec_mem[2] = pack(2, 0, 0);
        rec_mem[3] = pack(3, 0, 0);
        rec_mem[4] = pack(4, 4, 6);
        rec_mem[5] = pack(5, 5, 7);
        rec_mem[6] = pack(0, 8, 0);
        rec_mem[7] = pack(0, 11, 0);
        rec_mem[8] = pack(0, 5, 0);
        rec_mem[9] = pack(0, 6, 0);
        nrec = 10; nci = 2; nco = 4; cu = 1'b0;
        in_mem[0] = {28'h0, b, a}; in_mem[1] = '0;
        preload(32'hFFFF_FFFF, 32'h0);
        do_case("R4", 0);
        chk("R4", 32'(out_mem[0][1:0]),
            32'((a == 2'b11 || b == 2'b11) ? 2'b11 : (a == 2'b10 && b == 2'b10) ? 2'b10 : 2'b01),
            "and of two fanins");
        chk("R5", 32'(out_mem[0][5:4]),
            32'((a == 2'b11) ? 2'b11 : (a == 2'b01) ? 2'b10 : 2'b01), "inverted input");
        chk("R3", 32'(out_mem[0][7:6]), 32'(b), "input copied through");
        chk("R6", out_mem[0][31:8], 24'hFFFFFF, "untouched fields");
      end

    // R7: constant-one forcing of input entry 1
    cu = 1'b1;
    in_mem[0] = {28'h0, 2'b11, 2'b01};
    preload(32'h0, 32'h0);
    do_case("R7", 0);
    chk("R7", 32'(out_mem[0][7:6]), 32'd2, "entry 1 forced to one");
    cu = 1'b0;
    preload(32'h0, 32'h0);
    do_case("R7", 0);
    chk("R7", 32'(out_mem[0][7:6]), 32'd3, "entry 1 read normally");

    // R11 / R6: outputs crossing the word boundary over a patterned memory
    build(4, 10, 24);
    preload(32'h5A5A_5A5A, 32'hC3C3_C3C3);
    do_case("R11", 0);

    // R9: count mismatches
    build(3, 5, 4);
    nci = 4;
    preload(32'h0, 32'h0);
    do_case("R9", 0);
    build(3, 5, 4);
    nco = 2;
    do_case("R9", 0);

    // R10: extra start pulses during the walk
    build(5, 20, 10);
    preload(32'h1234_5678, 32'h9ABC_DEF0);
    do_case("R10", 3);
    do_case("R10", 10);

    // R8: minimal rounds
    clear_recs();
    nrec = 2; nci = 0; nco = 0;
    do_case("R8", 0);
    build(1, 0, 0);
    do_case("R8", 0);

    // random netlists: R3 R4 R5 R6 R11
    for (int t = 0; t < 30; t++) begin
      int ni, ng, no;
      ni = 1 + int'($urandom % 10);
      no = 1 + int'($urandom % 20);
      ng = int'($urandom % (62 - ni - no + 1));
      build(ni, ng, no);
      cu = 1'(($urandom % 2));
      preload($urandom, $urandom);
      do_case("R6", 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule